// File: doc/BRIEF.md
# Gated One-Shot Pulse Generator

This block is a clocked monostable. When a qualifying trigger event is seen, it drives `q` high for a programmed number of clock cycles, then returns to idle. `q_n` is always the opposite of `q`. Two trigger inputs have opposite edge senses. A falling edge on `fall_in` fires only while `rise_in` is high. A rising edge on `rise_in` fires only while `fall_in` is low. Each input therefore also gates the other.

An active-low `clr_n` forces the output idle and cuts a running pulse short. When `clr_n` is released while the trigger condition already holds (`fall_in` low, `rise_in` high), the release itself starts a pulse. Once a pulse is running it cannot be extended or restarted. Trigger edges that arrive during the pulse are dropped. The pulse length lives in a register written through `len_we`/`len_din`.

All three control inputs pass through two-flop synchronisers before edge detection. The state machine has two states:
- IDLE: `q` is low. The transition IDLE→RUN ("fire") is taken on a qualified trigger while the length is non-zero.
- RUN: `q` is high. RUN→IDLE is taken either at count expiry ("expire") or on a synchronised clear ("abort").

Top module: `gated_oneshot`

## Requirements
- R1: A high-to-low change of `fall_in` starts a pulse when, at the synchronised edge, `rise_in` is high and `clr_n` is high.
- R2: A low-to-high change of `rise_in` starts a pulse when, at the synchronised edge, `fall_in` is low and `clr_n` is high.
- R3: A low-to-high change of `clr_n` starts a pulse when `fall_in` is low and `rise_in` is high at that synchronised edge.
- R4: A low `clr_n` keeps `q` low. A low `clr_n` applied during a pulse ends it; `q` falls after the third rising clock edge following the change of `clr_n`.
- R5: While `fall_in` is high, edges on `rise_in` start nothing. While `rise_in` is low, edges on `fall_in` start nothing.
- R6: While a pulse runs, further edges on `fall_in` and `rise_in` neither extend nor restart it, and they are not remembered afterwards.
- R7: With length register value L ≥ 1, `q` stays high for exactly L clock cycles. L = 0 produces no pulse. When `len_we` is high at a rising edge, the register takes `len_din` at that edge.
- R8: `q_n` is the inverse of `q` in every cycle after reset.
- R9: An input change that is stable before rising edge k makes `q` rise just after edge k+2.
- R10: A qualifying trigger that reaches the state machine in the cycle after the pulse has ended starts a new pulse. A trigger that reaches it in the last pulse cycle is dropped.
- R11: A synchronous active-low `rst_n` drives `q` low, `q_n` high and the length register to its default (8). Input levels present while reset is released do not count as edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fall_in | input | 1 | Trigger input that fires on its falling edge |
| rise_in | input | 1 | Trigger input that fires on its rising edge |
| clr_n | input | 1 | Clear, active low; a rising edge may fire |
| len_we | input | 1 | Write strobe for the pulse length register |
| len_din | input | LEN_W | New pulse length in clock cycles |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Inverse of `q` |

## Verification
The bench sweeps the gap between two trigger edges across the end of a pulse. A design that queued triggers, or that retriggered, would show a pulse that is too long or an extra pulse. A design that was off by one at the RUN→IDLE boundary would lose the pulse that should follow immediately. The bench releases clear with the trigger levels already set; a design that treated clear only as a gate would never fire there. It also drives edges while the opposing input inhibits them, programs lengths of 0, 1 and 20, and releases reset with non-idle input levels. Each of these would expose spurious or missing pulses.

// File: rtl/os_pkg.sv
package os_pkg;
    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_RUN  = 1'b1
    } os_state_e;

    localparam int SIG_FALL = 0;
    localparam int SIG_RISE = 1;
    localparam int SIG_CLR  = 2;
    localparam int NUM_SIGS = 3;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [DEPTH-1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                // preload with the live level so release creates no edge
                sh <= {DEPTH{din[i]}};
            end else begin
                sh <= {sh[DEPTH-2:0], din[i]};
            end
        end
        assign sync_o[i] = sh[STAGES-1];
        assign prev_o[i] = sh[STAGES];
    end
endmodule

// File: rtl/os_trig.sv
module os_trig
    import os_pkg::*;
(
    input  logic [NUM_SIGS-1:0] sync_i,
    input  logic [NUM_SIGS-1:0] prev_i,
    output logic                trig_o,
    output logic                clr_ok_o
);
    logic fall_edge, rise_edge, clr_edge, armed;

    always_comb begin
        fall_edge = prev_i[SIG_FALL] & ~sync_i[SIG_FALL];
        rise_edge = ~prev_i[SIG_RISE] & sync_i[SIG_RISE];
        clr_edge  = ~prev_i[SIG_CLR] & sync_i[SIG_CLR];
        // condition: fall input low and rise input high, clear released
        armed     = ~sync_i[SIG_FALL] & sync_i[SIG_RISE] & sync_i[SIG_CLR];
        trig_o    = armed & (fall_edge | rise_edge | clr_edge);
        clr_ok_o  = sync_i[SIG_CLR];
    end
endmodule

// File: rtl/os_fsm.sv
module os_fsm
    import os_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int DEF_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             clr_ok_i,
    input  logic             len_we_i,
    input  logic [LEN_W-1:0] len_din_i,
    output logic             q_o,
    output logic             qn_o
);
    os_state_e        state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] len_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OS_IDLE: begin
                if (trig_i && len_q != '0) begin   // fire
                    state_d = OS_RUN;
                    cnt_d   = len_q - LEN_W'(1);
                end
            end
            OS_RUN: begin
                if (!clr_ok_i) begin               // abort
                    state_d = OS_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin    // expire
                    state_d = OS_IDLE;
                end else begin
                    cnt_d = cnt_q - LEN_W'(1);
                end
            end
            default: begin
                state_d = OS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
            len_q   <= LEN_W'(DEF_LEN);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (len_we_i) len_q <= len_din_i;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o  <= 1'b0;
            qn_o <= 1'b1;
        end else begin
            q_o  <= (state_d == OS_RUN);
            qn_o <= (state_d != OS_RUN);
        end
    end

    AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && trig_i && len_q != '0) |=> q_o);                   // R1
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_ok_i) |=> !q_o);                               // R4
    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_ok_i && cnt_q != '0) |=> q_o);                  // R6
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && len_q == '0) |=> !q_o);                            // R7
    AST_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        q_o != qn_o);                                               // R8
endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
    import os_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int DEF_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_in,
    input  logic             rise_in,
    input  logic             clr_n,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_din,
    output logic             q,
    output logic             q_n
);
    logic [NUM_SIGS-1:0] raw, sync_v, prev_v;
    logic                trig, clr_ok;

    always_comb begin
        raw           = '0;
        raw[SIG_FALL] = fall_in;
        raw[SIG_RISE] = rise_in;
        raw[SIG_CLR]  = clr_n;
    end

    os_sync #(.W(NUM_SIGS), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (raw),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    os_trig u_trig (
        .sync_i   (sync_v),
        .prev_i   (prev_v),
        .trig_o   (trig),
        .clr_ok_o (clr_ok)
    );

    os_fsm #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig),
        .clr_ok_i  (clr_ok),
        .len_we_i  (len_we),
        .len_din_i (len_din),
        .q_o       (q),
        .qn_o      (q_n)
    );
endmodule

// File: tb/gated_oneshot_tb_top.sv
`timescale 1ns/1ps
module gated_oneshot_tb_top;
    localparam int LEN_W   = 16;
    localparam int DEF_LEN = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a = 1'b1, b = 1'b1, c = 1'b1;
    logic             len_we = 1'b0;
    logic [LEN_W-1:0] len_din = '0;
    logic             q, q_n;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    model_on = 0;
    string cur_req = "R11";

    // model state
    logic [2:0] hist[$];
    int         rem = 0;
    int         mlen = DEF_LEN;

    always #2 clk = ~clk;

    gated_oneshot #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .fall_in(a), .rise_in(b), .clr_n(c),
        .len_we(len_we), .len_din(len_din), .q(q), .q_n(q_n)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: samples are {clr, rise, fall}
    always @(posedge clk) begin
        logic [2:0] cur, s2, s3;
        bit trig;
        cur = {c, b, a};
        if (!rst_n) begin
            hist.delete();
            repeat (3) hist.push_front(cur);
            rem  = 0;
            mlen = DEF_LEN;
        end else begin
            s2 = hist[1];
            s3 = hist[2];
            trig = s2[2] && !s2[0] && s2[1] &&
                   ((s3[0] && !s2[0]) || (!s3[1] && s2[1]) || (!s3[2] && s2[2]));
            if (rem > 0) begin
                if (!s2[2]) rem = 0;
                else rem = rem - 1;
            end else if (trig && mlen != 0) begin
                rem = mlen;
            end
            if (len_we) mlen = int'(len_din);
            hist.push_front(cur);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk(cur_req, q, rem > 0);
            chk("R8", q_n, ~q);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_len(int v);
        @(negedge clk); len_we = 1'b1; len_din = LEN_W'(v);
        @(negedge clk); len_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R11: reset with non-idle levels (A low, B high: armed)
        a = 1'b0; b = 1'b1; c = 1'b1;
        cyc(4);
        chk("R11", q, 1'b0);
        chk("R11", q_n, 1'b1);
        rst_n = 1'b1; model_on = 1;
        cyc(10);
        chk("R11", q, 1'b0);

        // R7: default length 8 via R2 trigger
        cur_req = "R7";
        b = 1'b0; cyc(3); b = 1'b1; cyc(14);

        // R1: falling A with B high
        cur_req = "R1";
        a = 1'b1; cyc(4); set_len(5);
        @(negedge clk); a = 1'b0;
        cyc(2); chk("R9", q, 1'b0);
        cyc(1); chk("R9", q, 1'b1);
        cyc(10);

        // R5: A fall with B low, B rise with A high
        cur_req = "R5";
        a = 1'b1; b = 1'b0; cyc(4);
        a = 1'b0; cyc(6); chk("R5", q, 1'b0);
        a = 1'b1; cyc(4);
        b = 1'b1; cyc(6); chk("R5", q, 1'b0);
        b = 1'b0; cyc(4);

        // R2: B rise with A low
        cur_req = "R2";
        a = 1'b0; cyc(4); b = 1'b1; cyc(10);

        // R3: clear release with trigger condition true
        cur_req = "R3";
        c = 1'b0; cyc(6); chk("R4", q, 1'b0);
        c = 1'b1; cyc(3); chk("R3", q, 1'b1);
        cyc(8);

        // R4: clear during a pulse
        cur_req = "R4";
        set_len(20);
        b = 1'b0; cyc(3); b = 1'b1; cyc(6);
        c = 1'b0; a = 1'b1; cyc(3); chk("R4", q, 1'b0);
        cyc(4); c = 1'b1; cyc(6);
        a = 1'b0; cyc(25);

        // R6: toggling inputs during a running pulse
        cur_req = "R6";
        b = 1'b0; cyc(3); b = 1'b1; cyc(4);
        for (int k = 0; k < 4; k++) begin
            b = 1'b0; cyc(1); b = 1'b1; cyc(1);
            a = 1'b1; cyc(1); a = 1'b0; cyc(1);
        end
        cyc(20); chk("R6", q, 1'b0);

        // R7: lengths 1 and 0
        cur_req = "R7";
        set_len(1);
        b = 1'b0; cyc(3); b = 1'b1; cyc(3); chk("R7", q, 1'b1);
        cyc(1); chk("R7", q, 1'b0); cyc(4);
        set_len(0);
        b = 1'b0; cyc(3); b = 1'b1; cyc(8); chk("R7", q, 1'b0);

        // R10: sweep the gap between two triggers around pulse end
        cur_req = "R10";
        set_len(3);
        for (int g = 0; g < 9; g++) begin
            b = 1'b0; cyc(1); b = 1'b1; cyc(g);
            b = 1'b0; cyc(1); b = 1'b1; cyc(12);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule